// File: doc/BRIEF.md
# Multi-channel command FIFO peek port

This block holds several circular command FIFOs in one shared storage array. Each channel owns a window of that array, set by a base slot and an inclusive limit slot. A small model of the channel push and pop logic fills and drains each window, and the pointers wrap from the limit back to the base rather than at a power of two.

Two debug paths read the stored words without disturbing the channels. The first is a peek register: software writes a control word that holds an enable, a channel number and an absolute slot address. One clock later the data register holds the word in that slot, and the pointer register shows the read and write pointers of the chosen channel. The usual sequence is to clear the control word first, then write it with enable, channel and address set. The second path is a walker. A start pulse with a channel number makes it stream every valid word of that channel, from the read pointer up to the write pointer, each with its slot index. It marks the final word with a last flag.

Top module: `cmdfifo_peek_top`

## Requirements
- R1: A push writes the word at the channel's write pointer and advances it by one. From the limit slot it moves to the base slot, and the limit slot is usable storage.
- R2: empty_o[c] is 1 exactly when channel c's read and write pointers are equal. Reset clears every pointer to 0, so all channels read empty. Configuring a channel sets both of its pointers to the new base.
- R3: A push to a full channel is dropped and leaves the write pointer unchanged. A channel is full when advancing its write pointer would land on its read pointer. A pop of an empty channel is ignored.
- R4: ptrs_o shows the channel selected by control bits 18:16. Its read pointer sits at bits ADDR_W-1:0 and its write pointer at bits 16+ADDR_W-1:16, and every other bit is 0. The register is updated in the cycle after the control write.
- R5: The control word holds the enable at bit 31, the channel at bits 18:16 and the absolute slot address at bits ADDR_W-1:0. peek_data_o returns the addressed word one clock after the control register changes. It reads 0 while the enable is 0.
- R6: Peek reads and walks never change any channel's read or write pointer.
- R7: A walk started on a non-empty channel emits one word per cycle, beginning two clock edges after the start. It begins at the read pointer, moves up by one per word and wraps from the limit slot to the base slot. walk_slot_o and walk_data_o carry each slot and its stored word.
- R8: walk_last_o is set on the word whose next slot equals the write pointer captured at start. The walk ends after that word.
- R9: A start on an empty channel produces no walk: walk_busy_o and walk_valid_o stay 0.
- R10: A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write a channel window |
| cfg_ch_i | input | 3 | Channel to configure |
| cfg_base_i | input | ADDR_W | Window base slot |
| cfg_limit_i | input | ADDR_W | Window limit slot (inclusive) |
| push_i | input | 1 | Push one word |
| push_ch_i | input | 3 | Channel to push to |
| push_data_i | input | DATA_W | Word to push |
| pop_i | input | 1 | Pop one word |
| pop_ch_i | input | 3 | Channel to pop from |
| ctrl_we_i | input | 1 | Write peek control word |
| ctrl_wdata_i | input | 32 | Peek control word |
| peek_data_o | output | DATA_W | Peek data register |
| ptrs_o | output | 32 | Selected channel pointers |
| empty_o | output | NUM_CH | Per-channel empty flags |
| walk_start_i | input | 1 | Start a walk |
| walk_ch_i | input | 3 | Channel to walk |
| walk_busy_o | output | 1 | Walk in progress |
| walk_valid_o | output | 1 | Walk word valid |
| walk_last_o | output | 1 | Final word of the walk |
| walk_slot_o | output | ADDR_W | Slot index of the walk word |
| walk_data_o | output | DATA_W | Walk word |

## Verification
The bench builds the block with eight channels, 6-bit slot addresses (64 slots) and 16-bit words. With these values every channel number is legal, and every pointer and address fits in the register fields. A small window of four slots becomes reachable, and a few pushes and pops are enough to fill it and force the write pointer to wrap from limit to base. In that state the read pointer sits above the write pointer. A walk from there has to cross the limit-to-base wrap and stop just before the captured write pointer. An untouched channel gives the empty-start case and the all-zero pointer readback.

// File: rtl/cmdfifo_peek_pkg.sv
package cmdfifo_peek_pkg;
  localparam int MAX_CH      = 8;
  localparam int CH_FIELD_W  = 3;
  localparam int CTRL_EN_BIT = 31;
  localparam int CTRL_CH_LSB = 16;
  localparam int PTR_WR_LSB  = 16;
endpackage

// File: rtl/cmdfifo_store.sv
module cmdfifo_store
  import cmdfifo_peek_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CH_FIELD_W-1:0] cfg_ch_i,
  input  logic [ADDR_W-1:0]     cfg_base_i,
  input  logic [ADDR_W-1:0]     cfg_limit_i,
  input  logic                  push_i,
  input  logic [CH_FIELD_W-1:0] push_ch_i,
  input  logic [DATA_W-1:0]     push_data_i,
  input  logic                  pop_i,
  input  logic [CH_FIELD_W-1:0] pop_ch_i,
  output logic [ADDR_W-1:0]     base_o  [NUM_CH],
  output logic [ADDR_W-1:0]     limit_o [NUM_CH],
  output logic [ADDR_W-1:0]     rd_o    [NUM_CH],
  output logic [ADDR_W-1:0]     wr_o    [NUM_CH],
  output logic [NUM_CH-1:0]     empty_o,
  input  logic [ADDR_W-1:0]     pa_addr_i,
  output logic [DATA_W-1:0]     pa_data_o,
  input  logic [ADDR_W-1:0]     pb_addr_i,
  output logic [DATA_W-1:0]     pb_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  function automatic logic [ADDR_W-1:0] step_slot(input logic [ADDR_W-1:0] cur,
                                                  input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] limit);
    return (cur == limit) ? base : cur + 1'b1;
  endfunction

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] base_q [NUM_CH];
  logic [ADDR_W-1:0] limit_q [NUM_CH];
  logic [ADDR_W-1:0] rd_q [NUM_CH];
  logic [ADDR_W-1:0] wr_q [NUM_CH];
  logic [NUM_CH-1:0] full_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic cfg_hit, push_hit, pop_hit;
    assign cfg_hit   = cfg_we_i && (cfg_ch_i == CH_FIELD_W'(c));
    assign push_hit  = push_i && (push_ch_i == CH_FIELD_W'(c)) && !full_w[c];
    assign pop_hit   = pop_i && (pop_ch_i == CH_FIELD_W'(c)) && !empty_o[c];
    assign empty_o[c] = (rd_q[c] == wr_q[c]);
    assign full_w[c]  = (step_slot(wr_q[c], base_q[c], limit_q[c]) == rd_q[c]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[c]  <= '0;
        limit_q[c] <= '0;
        rd_q[c]    <= '0;
        wr_q[c]    <= '0;
      end else if (cfg_hit) begin
        base_q[c]  <= cfg_base_i;
        limit_q[c] <= cfg_limit_i;
        rd_q[c]    <= cfg_base_i;
        wr_q[c]    <= cfg_base_i;
      end else begin
        if (push_hit) wr_q[c] <= step_slot(wr_q[c], base_q[c], limit_q[c]);
        if (pop_hit)  rd_q[c] <= step_slot(rd_q[c], base_q[c], limit_q[c]);
      end
    end

    assign base_o[c]  = base_q[c];
    assign limit_o[c] = limit_q[c];
    assign rd_o[c]    = rd_q[c];
    assign wr_o[c]    = wr_q[c];
  end

  logic              push_ch_ok;
  logic [CH_IW-1:0]  push_idx;
  logic              push_ok;
  assign push_ch_ok = int'(push_ch_i) < NUM_CH;
  assign push_idx   = push_ch_i[CH_IW-1:0];
  assign push_ok    = push_i && push_ch_ok && !full_w[push_idx] &&
                      !(cfg_we_i && cfg_ch_i == push_ch_i);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q[push_idx]] <= push_data_i;
  end

  assign pa_data_o = mem_q[pa_addr_i];
  assign pb_data_o = mem_q[pb_addr_i];

  // R3: a push into a full window leaves the write pointer where it was
  assert_full_push_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && push_ch_ok && full_w[push_idx] && !cfg_we_i
      |=> wr_q[$past(push_idx)] == $past(wr_q[push_idx]));

  // R2: a freshly configured channel is empty
  assert_cfg_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && int'(cfg_ch_i) < NUM_CH |=> empty_o[$past(cfg_ch_i[CH_IW-1:0])]);
endmodule

// File: rtl/cmdfifo_walker.sv
module cmdfifo_walker #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ch_empty_i,
  input  logic [ADDR_W-1:0] ch_rd_i,
  input  logic [ADDR_W-1:0] ch_wr_i,
  input  logic [ADDR_W-1:0] ch_base_i,
  input  logic [ADDR_W-1:0] ch_limit_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] slot_o,
  output logic [DATA_W-1:0] data_o
);
  logic              busy_q, valid_q, last_q;
  logic [ADDR_W-1:0] cur_q, end_q, base_q, limit_q, slot_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] nxt_w;
  logic              hit_w;

  assign nxt_w     = (cur_q == limit_q) ? base_q : cur_q + 1'b1;
  assign hit_w     = (nxt_w == end_q);
  assign rd_addr_o = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      cur_q   <= '0;
      end_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
      slot_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      if (busy_q) begin
        valid_q <= 1'b1;
        slot_q  <= cur_q;
        data_q  <= rd_data_i;
        last_q  <= hit_w;
        cur_q   <= nxt_w;
        if (hit_w) busy_q <= 1'b0;
      end else if (start_i && !ch_empty_i) begin
        busy_q  <= 1'b1;
        cur_q   <= ch_rd_i;
        end_q   <= ch_wr_i;
        base_q  <= ch_base_i;
        limit_q <= ch_limit_i;
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;
  assign slot_o  = slot_q;
  assign data_o  = data_q;

  assert_walk_slot_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (slot_o >= base_q) && (slot_o <= limit_q));

  assert_last_ends_walk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && last_o |=> !valid_o);

  assert_empty_start_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && ch_empty_i |=> !busy_o);

  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(end_q) && $stable(base_q) && $stable(limit_q));
endmodule

// File: rtl/cmdfifo_peek_regs.sv
module cmdfifo_peek_regs
  import cmdfifo_peek_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ctrl_we_i,
  input  logic [31:0]           ctrl_wdata_i,
  output logic [CH_FIELD_W-1:0] sel_ch_o,
  output logic [ADDR_W-1:0]     rd_addr_o,
  input  logic [DATA_W-1:0]     rd_data_i,
  input  logic [ADDR_W-1:0]     sel_rd_i,
  input  logic [ADDR_W-1:0]     sel_wr_i,
  output logic [DATA_W-1:0]     peek_data_o,
  output logic [31:0]           ptrs_o
);
  logic                  en_q;
  logic [CH_FIELD_W-1:0] ch_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [DATA_W-1:0]     peek_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ch_q   <= '0;
      addr_q <= '0;
      peek_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q   <= ctrl_wdata_i[CTRL_EN_BIT];
        ch_q   <= ctrl_wdata_i[CTRL_CH_LSB +: CH_FIELD_W];
        addr_q <= ctrl_wdata_i[ADDR_W-1:0];
      end
      peek_q <= en_q ? rd_data_i : '0;
    end
  end

  assign sel_ch_o    = ch_q;
  assign rd_addr_o   = addr_q;
  assign peek_data_o = peek_q;

  always_comb begin
    ptrs_o = '0;
    ptrs_o[ADDR_W-1:0]            = sel_rd_i;
    ptrs_o[PTR_WR_LSB +: ADDR_W]  = sel_wr_i;
  end

  assert_peek_zero_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> peek_data_o == '0);
endmodule

// File: rtl/cmdfifo_peek_top.sv
module cmdfifo_peek_top
  import cmdfifo_peek_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_ch_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_limit_i,
  input  logic              push_i,
  input  logic [2:0]        push_ch_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic [2:0]        pop_ch_i,
  input  logic              ctrl_we_i,
  input  logic [31:0]       ctrl_wdata_i,
  output logic [DATA_W-1:0] peek_data_o,
  output logic [31:0]       ptrs_o,
  output logic [NUM_CH-1:0] empty_o,
  input  logic              walk_start_i,
  input  logic [2:0]        walk_ch_i,
  output logic              walk_busy_o,
  output logic              walk_valid_o,
  output logic              walk_last_o,
  output logic [ADDR_W-1:0] walk_slot_o,
  output logic [DATA_W-1:0] walk_data_o
);
  localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [ADDR_W-1:0] base_w [NUM_CH];
  logic [ADDR_W-1:0] limit_w [NUM_CH];
  logic [ADDR_W-1:0] rd_w [NUM_CH];
  logic [ADDR_W-1:0] wr_w [NUM_CH];
  logic [ADDR_W-1:0] pa_addr, pb_addr;
  logic [DATA_W-1:0] pa_data, pb_data;

  cmdfifo_store #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_ch_i, .cfg_base_i, .cfg_limit_i,
    .push_i, .push_ch_i, .push_data_i, .pop_i, .pop_ch_i,
    .base_o(base_w), .limit_o(limit_w), .rd_o(rd_w), .wr_o(wr_w), .empty_o,
    .pa_addr_i(pa_addr), .pa_data_o(pa_data),
    .pb_addr_i(pb_addr), .pb_data_o(pb_data)
  );

  // walker channel select; unknown channels look empty
  logic              w_ok;
  logic [CH_IW-1:0]  w_idx;
  assign w_ok  = int'(walk_ch_i) < NUM_CH;
  assign w_idx = walk_ch_i[CH_IW-1:0];

  cmdfifo_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walker (
    .clk_i, .rst_ni,
    .start_i   (walk_start_i),
    .ch_empty_i(!w_ok || empty_o[w_idx]),
    .ch_rd_i   (rd_w[w_idx]),
    .ch_wr_i   (wr_w[w_idx]),
    .ch_base_i (base_w[w_idx]),
    .ch_limit_i(limit_w[w_idx]),
    .rd_addr_o (pb_addr),
    .rd_data_i (pb_data),
    .busy_o    (walk_busy_o),
    .valid_o   (walk_valid_o),
    .last_o    (walk_last_o),
    .slot_o    (walk_slot_o),
    .data_o    (walk_data_o)
  );

  logic [2:0]        p_ch;
  logic              p_ok;
  logic [CH_IW-1:0]  p_idx;
  logic [ADDR_W-1:0] p_rd, p_wr;
  assign p_ok  = int'(p_ch) < NUM_CH;
  assign p_idx = p_ch[CH_IW-1:0];
  assign p_rd  = p_ok ? rd_w[p_idx] : '0;
  assign p_wr  = p_ok ? wr_w[p_idx] : '0;

  cmdfifo_peek_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i,
    .sel_ch_o   (p_ch),
    .rd_addr_o  (pa_addr),
    .rd_data_i  (pa_data),
    .sel_rd_i   (p_rd),
    .sel_wr_i   (p_wr),
    .peek_data_o,
    .ptrs_o
  );
endmodule

// File: tb/cmdfifo_peek_top_tb_top.sv
module cmdfifo_peek_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              cfg_we_i = 0, push_i = 0, pop_i = 0, ctrl_we_i = 0, walk_start_i = 0;
  logic [2:0]        cfg_ch_i = 0, push_ch_i = 0, pop_ch_i = 0, walk_ch_i = 0;
  logic [ADDR_W-1:0] cfg_base_i = 0, cfg_limit_i = 0;
  logic [DATA_W-1:0] push_data_i = 0;
  logic [31:0]       ctrl_wdata_i = 0;
  logic [DATA_W-1:0] peek_data_o, walk_data_o;
  logic [31:0]       ptrs_o;
  logic [NUM_CH-1:0] empty_o;
  logic              walk_busy_o, walk_valid_o, walk_last_o;
  logic [ADDR_W-1:0] walk_slot_o;

  cmdfifo_peek_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_ch_i, .cfg_base_i, .cfg_limit_i,
    .push_i, .push_ch_i, .push_data_i, .pop_i, .pop_ch_i,
    .ctrl_we_i, .ctrl_wdata_i, .peek_data_o, .ptrs_o, .empty_o,
    .walk_start_i, .walk_ch_i, .walk_busy_o, .walk_valid_o, .walk_last_o,
    .walk_slot_o, .walk_data_o
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] ch, input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] l);
    cfg_we_i = 1; cfg_ch_i = ch; cfg_base_i = b; cfg_limit_i = l;
    @(negedge clk); cfg_we_i = 0;
  endtask

  task automatic push(input logic [2:0] ch, input logic [DATA_W-1:0] d);
    push_i = 1; push_ch_i = ch; push_data_i = d;
    @(negedge clk); push_i = 0;
  endtask

  task automatic pop(input logic [2:0] ch);
    pop_i = 1; pop_ch_i = ch;
    @(negedge clk); pop_i = 0;
  endtask

  // clear, then write the control word; sample after the data register loads
  task automatic peek(input logic [31:0] w);
    ctrl_we_i = 1; ctrl_wdata_i = 32'h0;
    @(negedge clk); ctrl_wdata_i = w;
    @(negedge clk); ctrl_we_i = 0;
    @(negedge clk);
  endtask

  int                n_got;
  logic [ADDR_W-1:0] got_slot [16];
  logic [DATA_W-1:0] got_data [16];
  logic              got_last [16];
  logic              saw_busy;

  task automatic walk(input logic [2:0] ch, input bit poke);
    n_got = 0;
    walk_start_i = 1; walk_ch_i = ch;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 0) begin
        saw_busy = walk_busy_o;
        if (poke) walk_ch_i = 3'd0; else walk_start_i = 0;
      end else if (k == 1) walk_start_i = 0;
      if (walk_valid_o && n_got < 16) begin
        got_slot[n_got] = walk_slot_o;
        got_data[n_got] = walk_data_o;
        got_last[n_got] = walk_last_o;
        n_got++;
      end
    end
  endtask

  // {ctrl word, expected data, expected ptrs}
  localparam int NV = 7;
  localparam logic [79:0] VEC [NV] = '{
    {32'h8000_0002, 16'hA002, 32'h0005_0000},
    {32'h8001_000B, 16'hA104, 32'h0009_000A},
    {32'h8001_0008, 16'hA105, 32'h0009_000A},
    {32'h0001_0008, 16'h0000, 32'h0009_000A},
    {32'h8003_0004, 16'hA004, 32'h0000_0000},
    {32'h8002_0009, 16'hA101, 32'h001E_001E},
    {32'h8000_0000, 16'hA000, 32'h0005_0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // reset state
    check("R2 reset empty", 32'(empty_o), 32'hFF);
    check("R5 reset peek", 32'(peek_data_o), 32'h0);
    check("R4 reset ptrs", ptrs_o, 32'h0);
    check("R9 reset walk idle", {30'h0, walk_busy_o, walk_valid_o}, 32'h0);

    cfg(3'd0, 6'd0, 6'd7);
    cfg(3'd1, 6'd8, 6'd11);
    cfg(3'd2, 6'd30, 6'd33);
    check("R2 cfg empty", 32'(empty_o), 32'hFF);

    for (int k = 0; k < 5; k++) push(3'd0, 16'hA000 + 16'(k));
    for (int k = 0; k < 3; k++) push(3'd1, 16'hA100 + 16'(k));
    push(3'd1, 16'hA103);          // ch1 full: dropped
    peek(32'h8001_0008);
    check("R3 full push dropped ptrs", ptrs_o, 32'h000B_0008);
    check("R3 full push no overwrite", 32'(peek_data_o), 32'hA100);
    pop(3'd1); pop(3'd1);
    push(3'd1, 16'hA104);          // slot 11, wraps wr to 8
    push(3'd1, 16'hA105);          // slot 8
    pop(3'd2);                     // empty: ignored
    check("R2 empty flags", 32'(empty_o), 32'hFC);
    peek(32'h8001_0000);
    check("R1 wrap ptrs", ptrs_o, 32'h0009_000A);

    // table walk
    for (int v = 0; v < NV; v++) begin
      peek(VEC[v][79:48]);
      check($sformatf("R5 peek data vec%0d", v), 32'(peek_data_o), 32'(VEC[v][47:32]));
      check($sformatf("R4 ptrs vec%0d", v), ptrs_o, VEC[v][31:0]);
    end

    // walk ch1 across the limit wrap, with a second start while busy
    walk(3'd1, 1'b1);
    check("R7 walk busy", 32'(saw_busy), 32'h1);
    check("R10 walk count", n_got, 3);
    check("R7 slot0", 32'(got_slot[0]), 32'd10);
    check("R7 data0", 32'(got_data[0]), 32'hA102);
    check("R7 slot1", 32'(got_slot[1]), 32'd11);
    check("R7 data1", 32'(got_data[1]), 32'hA104);
    check("R7 slot2 wrapped", 32'(got_slot[2]), 32'd8);
    check("R7 data2", 32'(got_data[2]), 32'hA105);
    check("R8 last flags", {29'h0, got_last[2], got_last[1], got_last[0]}, 32'h4);
    peek(32'h8001_0000);
    check("R6 ch1 pointers untouched", ptrs_o, 32'h0009_000A);

    walk(3'd0, 1'b0);
    check("R7 ch0 count", n_got, 5);
    for (int k = 0; k < 5; k++) begin
      check($sformatf("R7 ch0 slot%0d", k), 32'(got_slot[k]), k);
      check($sformatf("R7 ch0 data%0d", k), 32'(got_data[k]), 32'hA000 + k);
      check($sformatf("R8 ch0 last%0d", k), 32'(got_last[k]), (k == 4) ? 1 : 0);
    end
    peek(32'h8000_0000);
    check("R6 ch0 pointers untouched", ptrs_o, 32'h0005_0000);

    walk(3'd3, 1'b0);
    check("R9 empty start no busy", 32'(saw_busy), 32'h0);
    check("R9 empty start no words", n_got, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule